// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address presented to a synchronous burst memory. A full external address is captured whenever either of two start strobes is high at a rising clock edge. One strobe is meant for the processor side and the other for a memory controller. The two strobes have equal standing. After a start, the two least significant address bits come from an internal 2-bit beat counter, which moves forward only on edges where the advance input is high. A burst therefore covers four beats, and the upper address bits do not change during it.

The order of the four beats is chosen by the interleave input. When it is low, the low bits count upward from the start offset and wrap modulo 4. When it is high, the low bits equal the start offset XORed with the number of beats taken so far. The mode is captured together with the address, so a burst keeps the order it started with.

Bursting is optional. A fresh address can be loaded on every edge, and each one appears on the output after that edge with no idle cycle in between.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high, and on the first edge after it is released with no strobe, addr_out is all zeros.
- R2: If cpu_ads or ctl_ads is high at a rising edge, addr_out equals ld_addr after that edge. The start offset is ld_addr[1:0].
- R3: In linear order (interleave was 0 at the loading edge), each edge with advance high and no strobe makes addr_out[1:0] equal to (start offset + beats taken) modulo 4.
- R4: In interleaved order (interleave was 1 at the loading edge), addr_out[1:0] equals the start offset XOR (beats taken modulo 4).
- R5: The interleave input is sampled only on a loading edge. Changing it during a burst does not alter the order in use.
- R6: An edge with no strobe and advance low leaves addr_out unchanged.
- R7: When a strobe and advance are both high at the same edge, the load takes effect and the beat count restarts at zero.
- R8: Edges without a strobe never change addr_out[ADDR_W-1:2].
- R9: A strobe on every consecutive edge loads each new address in turn, one per cycle, with no gap.
- R10: A fifth beat (four advances after the start) returns the low bits to the start offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_ads | input | 1 | Processor-side burst start strobe |
| ctl_ads | input | 1 | Controller-side burst start strobe |
| advance | input | 1 | Step the beat counter |
| interleave | input | 1 | Burst order for the next load: 0 linear, 1 interleaved |
| ld_addr | input | ADDR_W | External address captured on a start |
| addr_out | output | ADDR_W | Current internal address |

## Verification
Each result is due exactly one edge after the inputs that cause it: a load, a step or a hold is visible after the rising edge that samples it, with no deeper pipeline. The bench drives inputs on the falling edge and computes the expected address from its own model of the burst. It queues that expected value right after the sampling rising edge, and a monitor compares it against addr_out on the following falling edge. This keeps every check in the one cycle in which the result becomes valid. All four start offsets are covered in both orders, together with wrap-around, mode changes during a burst, strobe-with-advance collisions and a load on every cycle.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } cmd_e;

    typedef struct packed {
        beat_t  start;
        beat_t  beat;
        order_e order;
    } burst_st_t;

    function automatic beat_t beat_offset(beat_t start, beat_t beat, order_e ord);
        beat_t res;
        if (ord == ORD_INTERLEAVE) begin
            res = start ^ beat;
        end else begin
            res = beat_t'(start + beat);
        end
        return res;
    endfunction

endpackage

// File: rtl/burst_cmd_arb.sv
module burst_cmd_arb
    import burst_pkg::*;
(
    input  logic cpu_ads,
    input  logic ctl_ads,
    input  logic advance,
    output cmd_e cmd
);
    always_comb begin
        if (cpu_ads || ctl_ads) begin
            cmd = CMD_LOAD;
        end else if (advance) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cmd_e   cmd,
    input  beat_t  load_ofs,
    input  order_e load_order,
    output beat_t  low_bits,
    output order_e order_q
);
    burst_st_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{start: '0, beat: '0, order: ORD_LINEAR};
        end else begin
            case (cmd)
                CMD_LOAD: st_q <= '{start: load_ofs, beat: '0, order: load_order};
                CMD_STEP: st_q.beat <= beat_t'(st_q.beat + 1'b1);
                default:  st_q <= st_q;
            endcase
        end
    end

    assign low_bits = beat_offset(st_q.start, st_q.beat, st_q.order);
    assign order_q  = st_q.order;
endmodule

// File: rtl/addr_hi_reg.sv
module addr_hi_reg #(
    parameter int HI_W = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [HI_W-1:0] d,
    output logic [HI_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_ads,
    input  logic              ctl_ads,
    input  logic              advance,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - BEAT_W;

    cmd_e            cmd;
    beat_t           low_bits;
    order_e          order_q;
    logic [HI_W-1:0] hi_q;
    order_e          load_order;

    assign load_order = interleave ? ORD_INTERLEAVE : ORD_LINEAR;

    burst_cmd_arb u_arb (
        .cpu_ads (cpu_ads),
        .ctl_ads (ctl_ads),
        .advance (advance),
        .cmd     (cmd)
    );

    burst_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .load_ofs   (ld_addr[BEAT_W-1:0]),
        .load_order (load_order),
        .low_bits   (low_bits),
        .order_q    (order_q)
    );

    addr_hi_reg #(.HI_W(HI_W)) u_hi (
        .clk  (clk),
        .rst  (rst),
        .load (cmd == CMD_LOAD),
        .d    (ld_addr[ADDR_W-1:BEAT_W]),
        .q    (hi_q)
    );

    assign addr_out = {hi_q, low_bits};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_ads,
    input logic              ctl_ads,
    input logic              advance,
    input logic [ADDR_W-1:0] ld_addr,
    input logic [ADDR_W-1:0] addr_out,
    input logic              order_q
);
    logic strobe;
    assign strobe = cpu_ads || ctl_ads;

    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        strobe |=> addr_out == $past(ld_addr));

    a_r7_load_beats_step: assert property (@(posedge clk) disable iff (rst)
        (strobe && advance) |=> addr_out[1:0] == $past(ld_addr[1:0]));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !advance) |=> $stable(addr_out));

    a_r8_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));

    a_r3_linear_step: assert property (@(posedge clk) disable iff (rst)
        (!strobe && advance && !order_q) |=> addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1));

    a_r4_interleave_toggle: assert property (@(posedge clk) disable iff (rst)
        (!strobe && advance && order_q) |=> addr_out[0] != $past(addr_out[0]));

    a_r5_order_kept: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> order_q == $past(order_q));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_ads  (cpu_ads),
    .ctl_ads  (ctl_ads),
    .advance  (advance),
    .ld_addr  (ld_addr),
    .addr_out (addr_out),
    .order_q  (order_q)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_ads = 1'b0;
    logic          ctl_ads = 1'b0;
    logic          advance = 1'b0;
    logic          interleave = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [AW-1:0] addr_out;

    int n_run  = 0;
    int n_fail = 0;

    typedef struct {
        logic [AW-1:0] exp;
        string         tag;
    } item_t;

    item_t sb[$];

    logic [AW-3:0] m_hi    = '0;
    logic [1:0]    m_start = '0;
    logic [1:0]    m_beat  = '0;
    logic          m_mode  = 1'b0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) uut (
        .clk        (clk),
        .rst        (rst),
        .cpu_ads    (cpu_ads),
        .ctl_ads    (ctl_ads),
        .advance    (advance),
        .interleave (interleave),
        .ld_addr    (ld_addr),
        .addr_out   (addr_out)
    );

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_run++;
            if (addr_out !== it.exp) begin
                n_fail++;
                $display("FAIL %s: addr_out=%h expected=%h", it.tag, addr_out, it.exp);
            end
        end
    end

    // Called just after a falling edge: drive, model the next rising edge, queue result.
    task automatic cyc(input logic c, input logic k, input logic a, input logic m,
                       input logic [AW-1:0] ad, input string tag);
        item_t it;
        cpu_ads = c; ctl_ads = k; advance = a; interleave = m; ld_addr = ad;
        if (c || k) begin
            m_hi = ad[AW-1:2]; m_start = ad[1:0]; m_beat = 2'd0; m_mode = m;
        end else if (a) begin
            m_beat = m_beat + 2'd1;
        end
        it.exp = {m_hi, (m_mode ? (m_start ^ m_beat) : 2'(m_start + m_beat))};
        it.tag = tag;
        @(posedge clk);
        #1 sb.push_back(it);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_run++;
        if (addr_out !== '0) begin
            n_fail++;
            $display("FAIL R1: addr_out=%h expected=0 during reset", addr_out);
        end
        rst = 1'b0;
        cyc(0, 0, 0, 0, 20'hABCDE, "R1");

        // All four offsets in both orders, five advances each (R10 wrap).
        for (int mode = 0; mode < 2; mode++) begin
            for (int s = 0; s < 4; s++) begin
                logic [AW-1:0] a;
                a = {18'(20'h1234 + s * 7 + mode * 101), 2'(s)};
                cyc(s[0], !s[0], 0, mode[0], a, "R2");
                for (int b = 0; b < 5; b++) begin
                    cyc(0, 0, 1, !mode[0], 20'h0, mode ? "R4" : "R3");
                    if (b == 1) cyc(0, 0, 0, mode[0], 20'hFFFFF, "R6");
                end
                cyc(0, 0, 1, 0, 20'h0, "R8");
                cyc(0, 0, 1, 0, 20'h0, "R10");
            end
        end

        // Mode changes during a burst are ignored.
        cyc(1, 0, 0, 0, 20'h55551, "R2");
        cyc(0, 0, 1, 1, 20'h0, "R5");
        cyc(0, 0, 1, 1, 20'h0, "R5");
        cyc(0, 1, 0, 1, 20'h33332, "R2");
        cyc(0, 0, 1, 0, 20'h0, "R5");
        cyc(0, 0, 1, 0, 20'h0, "R5");

        // Strobe together with advance: load wins.
        cyc(1, 0, 0, 1, 20'h77773, "R2");
        cyc(0, 0, 1, 1, 20'h0, "R4");
        cyc(0, 1, 1, 1, 20'h88881, "R7");
        cyc(0, 0, 1, 1, 20'h0, "R7");
        cyc(1, 1, 1, 0, 20'h99992, "R7");
        cyc(0, 0, 1, 0, 20'h0, "R7");

        // Load on every cycle.
        for (int i = 0; i < 10; i++) begin
            cyc(i[0], !i[0] || i == 4, i[1], i[2], 20'(32'h2468A + i * 32'h1357), "R9");
        end
        cyc(0, 0, 0, 0, 20'h0, "R6");
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule